// File: doc/BRIEF.md
# Serial Select-Line Pin Arbiter

This block stands between a clock-synchronous serial shift engine and the three pins that engine uses: a clock pin and two data pins. A select input decides whether those pins are driven or left floating. In slave role the select line is an active-low chip select. While it is low, clock edges from the pin reach the engine and the transmit pin is driven. While it is high, the data pins float and clock edges are dropped.

In master role the select line is a contention sense. High means this master owns the bus. Low means a second master is present. The block then floats every pin and raises a sticky fault flag. The engine keeps shifting through a fault, because only software clearing the run bits stops it. The fault flag may feed a shared interrupt line, which otherwise carries other serial events.

A small write port holds the configuration. Address 0 is the mode word and address 1 is the fault flag. The select line and the pin clock both pass through two-flop synchronizers before any decision uses them.

Top module: `selGuard`

## Requirements
- R1: After reset the block is in slave role, the fault flag is 0, the run bits are 000, interrupt routing is off (so `irqOut` follows `otherIrq`), and all three output enables are 0.
- R2: A mode write uses `wrAddr`=0 with these fields: `wrData[0]` transmit enable, `wrData[1]` receive enable, `wrData[2]` clock drive enable, `wrData[3]` role (1 = slave, 0 = master), `wrData[4]` fault interrupt select. In slave role with synchronized select low, `pinBOe` equals transmit enable, `pinAOe` and `sclkPinOe` are 0, and `engRxBit` follows `pinAIn`.
- R3: In slave role with select low, each rising and each falling edge on `sclkPinIn` gives exactly one one-cycle pulse on `engClkRise` or `engClkFall`. With select high, no pulse occurs and all output enables are 0.
- R4: In master role with select high and no fault, `sclkPinOe` equals clock drive enable and `pinAOe` equals transmit enable. `pinBOe` is 0 and `engRxBit` follows `pinBIn`.
- R5: In master role, a select low held from one falling clock edge sets the fault flag within three rising edges. While the flag is 1, all output enables are 0.
- R6: A flag write uses `wrAddr`=1. Writing `wrData[0]`=0 requests a clear, and writing 1 does nothing. The flag stays 1 until a clear takes effect. A clear in master role with select high takes effect at the write edge and restores pin drive.
- R7: In master role with select low, a clear request is ignored and the flag stays 1.
- R8: In slave role, a clear request always takes effect, whatever the select level.
- R9: A fault does not change the run bits. `modeRun` keeps its value until the next mode write.
- R10: With interrupt select 1, `irqOut` equals the fault flag. With interrupt select 0, `irqOut` equals `otherIrq`.
- R11: A clear request on the same edge that sets the fault flag leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| ssIn | input | 1 | Asynchronous select line from its pin |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | 0 = mode word, 1 = fault flag |
| wrData | input | 5 | Write data |
| sclkPinIn | input | 1 | Clock pin input level |
| sclkPinOut | output | 1 | Clock pin output level |
| sclkPinOe | output | 1 | Clock pin output enable |
| pinAIn | input | 1 | Data pin A input level |
| pinAOut | output | 1 | Data pin A output level |
| pinAOe | output | 1 | Data pin A output enable (transmit in master role) |
| pinBIn | input | 1 | Data pin B input level |
| pinBOut | output | 1 | Data pin B output level |
| pinBOe | output | 1 | Data pin B output enable (transmit in slave role) |
| engClkIn | input | 1 | Master clock from the shift engine |
| engTxBit | input | 1 | Transmit bit from the shift engine |
| engRxBit | output | 1 | Received bit to the shift engine |
| engClkRise | output | 1 | Accepted pin-clock rising-edge pulse |
| engClkFall | output | 1 | Accepted pin-clock falling-edge pulse |
| otherIrq | input | 1 | Other events sharing the interrupt line |
| irqOut | output | 1 | Shared interrupt output |
| faultFlag | output | 1 | Sticky contention fault flag |
| modeRun | output | 3 | Run bits to the shift engine |
| roleSlave | output | 1 | Current role, 1 = slave |

## Verification
Two functions can fall on the same clock edge: the hardware set of the fault flag and a software clear of that flag. The bench drops the select line in master role. Two falling edges later it places a clear request, so the request is captured on the same rising edge at which the synchronized low sets the flag. The flag must read 1 afterwards. The companion cases check a clear after select returns high, which must succeed, and a clear in slave role with select low, which must also succeed. These tell apart a block that drops the priority rule from one that drops the role condition.

// File: rtl/selGuardPkg.sv
`timescale 1ns / 1ps
package selGuardPkg;
  // Mode word layout
  localparam int RUN_W      = 3;
  localparam int RUN_TX     = 0;
  localparam int RUN_RX     = 1;
  localparam int RUN_CLK    = 2;
  localparam int ROLE_BIT   = 3;
  localparam int IRQSEL_BIT = 4;
  localparam int CFG_W      = 5;

  // Write addresses
  localparam logic ADDR_MODE = 1'b0;
  localparam logic ADDR_FLAG = 1'b1;

  // Strobes from control to datapath
  typedef struct packed {
    logic swapPins;   // slave pin assignment
    logic acceptClk;  // pin clock edges reach the engine
    logic driveClk;   // clock pin driven
    logic driveData;  // transmit pin driven
  } guardStrobes_t;
endpackage

// File: rtl/selGuardSync.sv
`timescale 1ns / 1ps
module selGuardSync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk) begin
        if (!rstN) chain <= RESET_VAL;
        else       chain <= asyncIn;
      end
    end else begin : gChain
      always_ff @(posedge clk) begin
        if (!rstN) chain <= {STAGES{RESET_VAL}};
        else       chain <= {chain[LAST-1:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[LAST];
endmodule

// File: rtl/selGuardCtrl.sv
`timescale 1ns / 1ps
module selGuardCtrl
  import selGuardPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ssIn,
  input  logic               wrEn,
  input  logic               wrAddr,
  input  logic [CFG_W-1:0]   wrData,
  input  logic               otherIrq,
  output guardStrobes_t      strobes,
  output logic               faultFlag,
  output logic [RUN_W-1:0]   modeRun,
  output logic               roleSlave,
  output logic               irqOut
);
  logic ssSync;
  logic irqSel;
  logic modeWr;
  logic clrReq;
  logic setCond;
  logic clrOk;

  selGuardSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) ssSyncInst (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(ssIn),
    .syncOut(ssSync)
  );

  assign modeWr  = wrEn && (wrAddr == ADDR_MODE);
  assign clrReq  = wrEn && (wrAddr == ADDR_FLAG) && !wrData[0];
  assign setCond = !roleSlave && !ssSync;
  assign clrOk   = clrReq && (roleSlave || ssSync);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeRun   <= '0;
      roleSlave <= 1'b1;
      irqSel    <= 1'b0;
    end else if (modeWr) begin
      modeRun   <= wrData[RUN_W-1:0];
      roleSlave <= wrData[ROLE_BIT];
      irqSel    <= wrData[IRQSEL_BIT];
    end
  end

  // Hardware set wins over a clear on the same edge
  always_ff @(posedge clk) begin
    if (!rstN)        faultFlag <= 1'b0;
    else if (setCond) faultFlag <= 1'b1;
    else if (clrOk)   faultFlag <= 1'b0;
  end

  always_comb begin
    strobes.swapPins  = roleSlave;
    strobes.acceptClk = roleSlave && !ssSync;
    strobes.driveClk  = !roleSlave && ssSync && !faultFlag && modeRun[RUN_CLK];
    strobes.driveData = !faultFlag && modeRun[RUN_TX] &&
                        (roleSlave ? !ssSync : ssSync);
  end

  assign irqOut = irqSel ? faultFlag : otherIrq;

  assert_set_on_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!roleSlave && !ssSync) |=> faultFlag);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (faultFlag && !clrReq) |=> faultFlag);

  assert_clear_blocked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !roleSlave && !ssSync) |=> faultFlag);

  assert_slave_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && roleSlave) |=> !faultFlag);

  assert_run_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
    !modeWr |=> $stable(modeRun));
endmodule

// File: rtl/selGuardPath.sv
`timescale 1ns / 1ps
module selGuardPath
  import selGuardPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  guardStrobes_t strobes,
  input  logic          sclkPinIn,
  input  logic          pinAIn,
  input  logic          pinBIn,
  input  logic          engClkIn,
  input  logic          engTxBit,
  output logic          sclkPinOut,
  output logic          sclkPinOe,
  output logic          pinAOut,
  output logic          pinAOe,
  output logic          pinBOut,
  output logic          pinBOe,
  output logic          engRxBit,
  output logic          engClkRise,
  output logic          engClkFall
);
  logic sclkSync;
  logic sclkPrev;

  selGuardSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sclkSyncInst (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(sclkPinIn),
    .syncOut(sclkSync)
  );

  always_ff @(posedge clk) begin
    if (!rstN) sclkPrev <= 1'b1;
    else       sclkPrev <= sclkSync;
  end

  assign engClkRise = strobes.acceptClk && sclkSync && !sclkPrev;
  assign engClkFall = strobes.acceptClk && !sclkSync && sclkPrev;

  assign sclkPinOut = engClkIn;
  assign sclkPinOe  = strobes.driveClk;

  assign pinAOut  = engTxBit;
  assign pinBOut  = engTxBit;
  assign pinAOe   = strobes.driveData && !strobes.swapPins;
  assign pinBOe   = strobes.driveData && strobes.swapPins;
  assign engRxBit = strobes.swapPins ? pinAIn : pinBIn;
endmodule

// File: rtl/selGuard.sv
`timescale 1ns / 1ps
module selGuard
  import selGuardPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ssIn,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [CFG_W-1:0] wrData,
  input  logic             sclkPinIn,
  output logic             sclkPinOut,
  output logic             sclkPinOe,
  input  logic             pinAIn,
  output logic             pinAOut,
  output logic             pinAOe,
  input  logic             pinBIn,
  output logic             pinBOut,
  output logic             pinBOe,
  input  logic             engClkIn,
  input  logic             engTxBit,
  output logic             engRxBit,
  output logic             engClkRise,
  output logic             engClkFall,
  input  logic             otherIrq,
  output logic             irqOut,
  output logic             faultFlag,
  output logic [RUN_W-1:0] modeRun,
  output logic             roleSlave
);
  guardStrobes_t strobes;

  selGuardCtrl #(.SYNC_STAGES(SYNC_STAGES)) ctrlInst (
    .clk      (clk),
    .rstN     (rstN),
    .ssIn     (ssIn),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .otherIrq (otherIrq),
    .strobes  (strobes),
    .faultFlag(faultFlag),
    .modeRun  (modeRun),
    .roleSlave(roleSlave),
    .irqOut   (irqOut)
  );

  selGuardPath #(.SYNC_STAGES(SYNC_STAGES)) pathInst (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sclkPinIn (sclkPinIn),
    .pinAIn    (pinAIn),
    .pinBIn    (pinBIn),
    .engClkIn  (engClkIn),
    .engTxBit  (engTxBit),
    .sclkPinOut(sclkPinOut),
    .sclkPinOe (sclkPinOe),
    .pinAOut   (pinAOut),
    .pinAOe    (pinAOe),
    .pinBOut   (pinBOut),
    .pinBOe    (pinBOe),
    .engRxBit  (engRxBit),
    .engClkRise(engClkRise),
    .engClkFall(engClkFall)
  );

  assert_hiz_on_fault_R5: assert property (@(posedge clk) disable iff (!rstN)
    faultFlag |-> (!sclkPinOe && !pinAOe && !pinBOe));

  assert_master_b_input_R4: assert property (@(posedge clk) disable iff (!rstN)
    !roleSlave |-> !pinBOe);

  assert_slave_no_clk_drive_R2: assert property (@(posedge clk) disable iff (!rstN)
    roleSlave |-> (!sclkPinOe && !pinAOe));
endmodule

// File: tb/selGuard_test.sv
`timescale 1ns / 1ps
module selGuard_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ssIn = 1'b1;
  logic       wrEn = 1'b0;
  logic       wrAddr = 1'b0;
  logic [4:0] wrData = '0;
  logic       sclkPinIn = 1'b1;
  logic       pinAIn = 1'b0;
  logic       pinBIn = 1'b0;
  logic       engClkIn = 1'b0;
  logic       engTxBit = 1'b0;
  logic       otherIrq = 1'b0;
  logic       sclkPinOut, sclkPinOe, pinAOut, pinAOe, pinBOut, pinBOe;
  logic       engRxBit, engClkRise, engClkFall, irqOut, faultFlag, roleSlave;
  logic [2:0] modeRun;

  int checks = 0;
  int fails  = 0;
  int riseCnt, fallCnt;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  selGuard uut (
    .clk(clk), .rstN(rstN), .ssIn(ssIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .sclkPinIn(sclkPinIn), .sclkPinOut(sclkPinOut),
    .sclkPinOe(sclkPinOe), .pinAIn(pinAIn), .pinAOut(pinAOut), .pinAOe(pinAOe),
    .pinBIn(pinBIn), .pinBOut(pinBOut), .pinBOe(pinBOe), .engClkIn(engClkIn),
    .engTxBit(engTxBit), .engRxBit(engRxBit), .engClkRise(engClkRise),
    .engClkFall(engClkFall), .otherIrq(otherIrq), .irqOut(irqOut),
    .faultFlag(faultFlag), .modeRun(modeRun), .roleSlave(roleSlave)
  );

  // {role, ss, clr, expFault, expClkOe, expAOe, expBOe}
  localparam logic [6:0] VECS [10] = '{
    7'b1_0_0_0_001,
    7'b1_1_0_0_000,
    7'b0_1_0_0_110,
    7'b0_0_1_1_000,
    7'b0_1_0_1_000,
    7'b0_1_1_0_110,
    7'b0_0_0_1_000,
    7'b1_0_1_0_001,
    7'b0_0_0_1_000,
    7'b1_1_1_0_000
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic addr, input logic [4:0] data);
    wrAddr = addr;
    wrData = data;
    wrEn   = 1'b1;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  task automatic countEdges(input int n);
    repeat (n) begin
      @(negedge clk);
      riseCnt += int'(engClkRise);
      fallCnt += int'(engClkFall);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    ticks(3);
    rstN = 1'b1;
    ticks(1);
    // R1 reset state
    chk("R1 role", int'(roleSlave), 1);
    chk("R1 fault", int'(faultFlag), 0);
    chk("R1 run", int'(modeRun), 0);
    chk("R1 oe", int'({sclkPinOe, pinAOe, pinBOe}), 0);
    otherIrq = 1'b1;
    ticks(1);
    chk("R1 irq routing off", int'(irqOut), 1);
    otherIrq = 1'b0;

    // Vector walk: R2 R4 R5 R6 R7 R8 R10
    foreach (VECS[i]) begin
      writeReg(1'b0, {1'b1, VECS[i][6], 3'b111});
      ssIn = VECS[i][5];
      ticks(4);
      if (VECS[i][4]) writeReg(1'b1, 5'b00000);
      else ticks(1);
      chk($sformatf("R5 R6 R7 R8 fault vec%0d", i), int'(faultFlag), int'(VECS[i][3]));
      chk($sformatf("R2 R4 R5 oe vec%0d", i), int'({sclkPinOe, pinAOe, pinBOe}),
          int'(VECS[i][2:0]));
      chk($sformatf("R10 irq vec%0d", i), int'(irqOut), int'(VECS[i][3]));
      chk($sformatf("R9 run vec%0d", i), int'(modeRun), 7);
    end

    // R6: writing 1 to the flag is not a clear
    writeReg(1'b0, 5'b10111);
    ssIn = 1'b0;
    ticks(4);
    ssIn = 1'b1;
    ticks(4);
    writeReg(1'b1, 5'b00001);
    chk("R6 write one keeps flag", int'(faultFlag), 1);
    writeReg(1'b1, 5'b00000);
    chk("R6 clear restores drive", int'({sclkPinOe, pinAOe, pinBOe}), 6);

    // R5 timing: set within three rising edges
    ssIn = 1'b0;
    ticks(2);
    chk("R5 not yet set", int'(faultFlag), 0);
    ticks(1);
    chk("R5 set at third edge", int'(faultFlag), 1);
    ssIn = 1'b1;
    ticks(4);
    writeReg(1'b1, 5'b00000);

    // R11: clear captured on the same edge as the set
    ssIn = 1'b0;
    ticks(2);
    writeReg(1'b1, 5'b00000);
    chk("R11 set beats clear", int'(faultFlag), 1);
    ssIn = 1'b1;
    ticks(4);
    writeReg(1'b1, 5'b00000);
    chk("R11 later clear", int'(faultFlag), 0);

    // R4: receive path in master role
    pinAIn = 1'b1; pinBIn = 1'b0;
    ticks(1);
    chk("R4 rx from B low", int'(engRxBit), 0);
    pinAIn = 1'b0; pinBIn = 1'b1;
    ticks(1);
    chk("R4 rx from B high", int'(engRxBit), 1);

    // R10: routing off passes otherIrq
    writeReg(1'b0, 5'b00111);
    otherIrq = 1'b1;
    ticks(1);
    chk("R10 other irq", int'(irqOut), 1);
    otherIrq = 1'b0;

    // R2 and R3: slave role clock acceptance
    writeReg(1'b0, 5'b01101);
    ssIn = 1'b0;
    pinAIn = 1'b1; pinBIn = 1'b0;
    ticks(4);
    chk("R2 rx from A", int'(engRxBit), 1);
    chk("R2 tx on B", int'({sclkPinOe, pinAOe, pinBOe}), 1);
    riseCnt = 0; fallCnt = 0;
    for (int k = 0; k < 5; k++) begin
      sclkPinIn = 1'b0;
      countEdges(3);
      sclkPinIn = 1'b1;
      countEdges(3);
    end
    countEdges(3);
    chk("R3 rises accepted", riseCnt, 5);
    chk("R3 falls accepted", fallCnt, 5);

    ssIn = 1'b1;
    ticks(4);
    riseCnt = 0; fallCnt = 0;
    for (int k = 0; k < 5; k++) begin
      sclkPinIn = 1'b0;
      countEdges(3);
      sclkPinIn = 1'b1;
      countEdges(3);
    end
    chk("R3 rises ignored", riseCnt, 0);
    chk("R3 falls ignored", fallCnt, 0);
    chk("R3 oe off", int'({sclkPinOe, pinAOe, pinBOe}), 0);

    finishRun();
  end
endmodule